// File: doc/BRIEF.md
# Serial Line Transmitter with Ready Handshake

This block takes bytes from a transmission buffer and sends them bit by bit on one serial data line. Timing comes from a line clock supplied from outside, which can run anywhere from standstill up to 2.048 MHz and has no fixed relation to the system clock. The line clock and the two receiver readiness inputs are brought into the system clock domain through two-flop synchronizers. Every rising line-clock edge detected there is one bit slot.

An active-low control output, the C line, is driven low while real data bits are on the line. The transmitter sends a data bit only when two receiver inputs are both high: the clear-to-send input (the I line) and the ready input (the R line). In every other slot the data line idles at 1 and the control output stays high. Bytes come from the buffer side through a one-byte holding register. The holding register asks for a byte with a request output and accepts it on an acknowledge.

The controller has four states. ST_EMPTY means no byte is held. ST_STALL means a byte is waiting for the receiver to become ready. ST_SEND means a data bit is on the line. ST_PAUSE means a byte was interrupted part way through. The transitions, each taken only on a detected line edge, are:
- ST_EMPTY to ST_SEND (a byte is held and the receiver is ready).
- ST_EMPTY to ST_STALL (a byte is held and the receiver is not ready).
- ST_STALL to ST_SEND (the receiver becomes ready).
- ST_SEND to ST_SEND (the next bit, or the next byte at a byte boundary).
- ST_SEND to ST_PAUSE (the receiver is not ready in the middle of a byte).
- ST_SEND to ST_STALL (byte boundary, a byte is held, the receiver is not ready).
- ST_SEND to ST_EMPTY (byte boundary with nothing held).
- ST_PAUSE to ST_SEND (the receiver is ready again).

Top module: `x21_serial_tx`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `txd_o` is 1, `ctl_n_o` is 1 and `buf_req_o` is 1.
- R2: `buf_req_o` is high exactly when the holding register is empty. A byte is captured in the cycle where `buf_req_o` and `buf_ack_i` are both high, and `buf_req_o` is low in the following cycle.
- R3: Bytes leave most significant bit first, one bit per rising line-clock edge. `ctl_n_o` is 0 while each data bit is on `txd_o`.
- R4: A data bit is presented only if `rcv_clear_i` and `rcv_ready_i` were both 1 at the line edge that starts it. Otherwise `txd_o` is 1 and `ctl_n_o` is 1.
- R5: If readiness drops in the middle of a byte, the remaining bits are held back with the line idle. They resume where they stopped once both inputs are 1 again, with no bit lost or repeated.
- R6: When no byte is held at a byte boundary, the line idles (`txd_o` = 1, `ctl_n_o` = 1) until a byte arrives. That byte starts at the next rising line edge at which the receiver is ready.
- R7: When the next byte is already held at a byte boundary and the receiver is ready, it follows with no idle slot in between.
- R8: Without a rising line-clock edge, `txd_o` and `ctl_n_o` do not change.
- R9: `buf_ack_i` asserted while `buf_req_o` is low is ignored, and the held byte is not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk_i | input | 1 | Line clock, asynchronous to `clk`, 0 to 2.048 MHz |
| rcv_clear_i | input | 1 | Receiver clear-to-send, I line, active high |
| rcv_ready_i | input | 1 | Receiver ready, R line, active high |
| buf_req_o | output | 1 | Request for a byte from the buffer side |
| buf_ack_i | input | 1 | Buffer side presents a byte on `buf_data_i` |
| buf_data_i | input | 8 | Byte from the buffer side |
| txd_o | output | 1 | Serial data, idles at 1 |
| ctl_n_o | output | 1 | C line, low while data bits are sent |

## Verification
The tricky case is when the end of a byte and a drop in receiver readiness fall on the same line edge. The controller must then choose between carrying on with the next byte, going to the stall state, and going to the empty state, all in a single transition. The bench provokes this by queueing a third byte and pulling the R line low right after the last bit of the second byte has been sampled. The result is judged at the ports: the line must go idle with the control output high, and once readiness returns the whole third byte must appear, intact and MSB first. A second case where two things meet is a capture from the buffer side and a rising line edge landing close together. This is covered by refilling the holding register during back-to-back bytes and checking that no slot is lost.

// File: rtl/x21tx_pkg.sv
package x21tx_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_STALL = 2'd1,
        ST_SEND  = 2'd2,
        ST_PAUSE = 2'd3
    } tx_state_t;

endpackage

// File: rtl/x21tx_sync.sv
module x21tx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/x21tx_edge.sv
module x21tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/x21tx_hold.sv
module x21tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              req_o,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (!full_q && ack_i) begin
            full_q <= 1'b1;
            data_q <= data_i;
        end
    end

    assign req_o  = ~full_q;
    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/x21tx_fsm.sv
module x21tx_fsm
    import x21tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              ready_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    output logic              take_o,
    output logic              txd_o,
    output logic              ctl_n_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              at_last;
    logic              load;
    logic              shift;

    assign at_last = (cnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (rise_i && hold_full_i) state_d = ready_i ? ST_SEND : ST_STALL;
            ST_STALL: if (rise_i && ready_i)     state_d = ST_SEND;
            ST_SEND: begin
                if (rise_i) begin
                    if (at_last) begin
                        if (hold_full_i) state_d = ready_i ? ST_SEND : ST_STALL;
                        else             state_d = ST_EMPTY;
                    end else begin
                        state_d = ready_i ? ST_SEND : ST_PAUSE;
                    end
                end
            end
            ST_PAUSE: if (rise_i && ready_i)     state_d = ST_SEND;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // byte load and bit advance
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        unique case (state_q)
            ST_EMPTY, ST_STALL: load = rise_i && hold_full_i && ready_i;
            ST_SEND: begin
                load  = rise_i && at_last && hold_full_i && ready_i;
                shift = rise_i && !at_last;
            end
            ST_PAUSE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= hold_data_i;
            cnt_q   <= '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b1};
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        take_o  = load;
        txd_o   = 1'b1;
        ctl_n_o = 1'b1;
        unique case (state_q)
            ST_SEND: begin
                txd_o   = shreg_q[DATA_W-1];
                ctl_n_o = 1'b0;
            end
            ST_EMPTY, ST_STALL, ST_PAUSE: ;
        endcase
    end

endmodule

// File: rtl/x21_serial_tx.sv
module x21_serial_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk_i,
    input  logic              rcv_clear_i,
    input  logic              rcv_ready_i,
    output logic              buf_req_o,
    input  logic              buf_ack_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              txd_o,
    output logic              ctl_n_o
);

    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] synced;
    logic              line_lvl;
    logic              rise_evt;
    logic              rdy_both;
    logic              hold_full;
    logic              take;
    logic [DATA_W-1:0] hold_data;

    assign raw_in = {line_clk_i, rcv_clear_i, rcv_ready_i};

    x21tx_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    assign line_lvl = synced[2];
    assign rdy_both = synced[1] & synced[0];

    x21tx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (line_lvl),
        .rise_o  (rise_evt)
    );

    x21tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (buf_ack_i),
        .data_i (buf_data_i),
        .take_i (take),
        .req_o  (buf_req_o),
        .full_o (hold_full),
        .data_o (hold_data)
    );

    x21tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise_evt),
        .ready_i     (rdy_both),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .take_o      (take),
        .txd_o       (txd_o),
        .ctl_n_o     (ctl_n_o)
    );

endmodule

// File: rtl/x21_serial_tx_chk.sv
module x21_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic txd_o,
    input logic ctl_n_o,
    input logic buf_req_o,
    input logic buf_ack_i,
    input logic rise_evt,
    input logic rdy_both
);

    // R1: reset leaves the line idle and the request raised
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (txd_o && ctl_n_o && buf_req_o));

    // R2: a completed handshake fills the holding register
    a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req_o && buf_ack_i) |=> !buf_req_o);

    // R4: data starts only after both receiver inputs were seen high
    a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_n_o) |-> $past(rdy_both));

    // R8: line outputs move only after a detected line edge
    a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_evt |=> ($stable(txd_o) && $stable(ctl_n_o)));

endmodule

bind x21_serial_tx x21_serial_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd_o     (txd_o),
    .ctl_n_o   (ctl_n_o),
    .buf_req_o (buf_req_o),
    .buf_ack_i (buf_ack_i),
    .rise_evt  (rise_evt),
    .rdy_both  (rdy_both)
);

// File: tb/x21_serial_tx_test.sv
module x21_serial_tx_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_clk;
    logic       cts;
    logic       rdy;
    logic       buf_req;
    logic       buf_ack;
    logic [7:0] buf_data;
    logic       txd;
    logic       ctl_n;

    always #4 clk = ~clk;

    x21_serial_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_clk_i  (line_clk),
        .rcv_clear_i (cts),
        .rcv_ready_i (rdy),
        .buf_req_o   (buf_req),
        .buf_ack_i   (buf_ack),
        .buf_data_i  (buf_data),
        .txd_o       (txd),
        .ctl_n_o     (ctl_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // buffer-side models
    logic [7:0] fq [16];
    int         fq_n = 0;
    int         fq_i = 0;
    bit         feed_on = 1'b0;
    logic       feed_ack = 1'b0;
    logic [7:0] feed_data = 8'h00;
    logic       man_ack = 1'b0;
    logic [7:0] man_data = 8'h00;

    assign buf_ack  = feed_on ? feed_ack  : man_ack;
    assign buf_data = feed_on ? feed_data : man_data;

    always @(negedge clk) begin
        if (feed_on && buf_req && fq_i < fq_n) begin
            feed_ack  <= 1'b1;
            feed_data <= fq[fq_i];
            fq_i      <= fq_i + 1;
        end else begin
            feed_ack <= 1'b0;
        end
    end

    // stimulus table: byte sent, same byte bit-reversed (line order, LSB = first bit)
    localparam logic [15:0] VEC [5] = '{16'hC1_83, 16'h12_48, 16'hF0_0F, 16'h01_80, 16'hA6_65};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line_cycle(output logic b, output logic c);
        line_clk = 1'b1;
        repeat (8) @(negedge clk);
        line_clk = 1'b0;
        repeat (8) @(negedge clk);
        b = txd;
        c = ctl_n;
    endtask

    task automatic set_rdy(input logic i_line, input logic r_line);
        cts = i_line;
        rdy = r_line;
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] v);
        fq[fq_n] = v;
        fq_n++;
        repeat (4) @(negedge clk);
    endtask

    // collect n bits; ctl_seen_high set if C line was high in any of them
    task automatic get_bits(input int n, inout logic [7:0] v, output logic ctl_seen_high);
        logic b, c;
        ctl_seen_high = 1'b0;
        for (int k = 0; k < n; k++) begin
            line_cycle(b, c);
            v = {v[6:0], b};
            if (c) ctl_seen_high = 1'b1;
        end
    endtask

    task automatic expect_idle(input string tag, input int n);
        logic b, c;
        for (int k = 0; k < n; k++) begin
            line_cycle(b, c);
            check(tag, {30'd0, c, b}, 32'd3);
        end
    endtask

    initial begin
        logic       b, c, hi;
        logic [7:0] v;
        logic       sb, sc;
        rst_n    = 1'b0;
        line_clk = 1'b0;
        cts      = 1'b0;
        rdy      = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 txd after reset", {31'd0, txd}, 32'd1);
        check("R1 ctl_n after reset", {31'd0, ctl_n}, 32'd1);
        check("R1 req after reset", {31'd0, buf_req}, 32'd1);

        // table walk: five bytes back to back, MSB first, no idle slot
        for (int e = 0; e < 5; e++) fq[e] = VEC[e][15:8];
        fq_n    = 5;
        feed_on = 1'b1;
        set_rdy(1'b1, 1'b1);
        repeat (4) @(negedge clk);
        for (int e = 0; e < 5; e++) begin
            for (int k = 0; k < 8; k++) begin
                line_cycle(b, c);
                check("R3/R7 table bit", {30'd0, c, b}, {30'd0, 1'b0, VEC[e][k]});
            end
        end

        // empty at boundary: idle until a new byte, then frozen clock mid-byte
        expect_idle("R6 empty idle", 3);
        push(8'h96);
        v = 8'h00;
        get_bits(3, v, hi);
        check("R6 first bits after refill", {23'd0, hi, v}, {23'd0, 1'b0, 5'd0, 3'b100});
        sb = txd;
        sc = ctl_n;
        repeat (40) @(negedge clk);
        check("R8 txd frozen", {31'd0, txd}, {31'd0, sb});
        check("R8 ctl_n frozen", {31'd0, ctl_n}, {31'd0, sc});
        get_bits(5, v, hi);
        check("R6 byte after refill", {23'd0, hi, v}, {23'd0, 1'b0, 8'h96});
        expect_idle("R6 idle again", 1);

        // readiness gating: each line alone is not enough
        set_rdy(1'b0, 1'b1);
        push(8'h5C);
        expect_idle("R4 I low", 2);
        set_rdy(1'b1, 1'b0);
        expect_idle("R4 R low", 2);
        set_rdy(1'b1, 1'b1);
        get_bits(8, v, hi);
        check("R4 byte once ready", {23'd0, hi, v}, {23'd0, 1'b0, 8'h5C});

        // mid-byte pause, then readiness drop on a byte boundary
        push(8'hB4);
        push(8'h69);
        push(8'hE2);
        get_bits(3, v, hi);
        set_rdy(1'b1, 1'b0);
        expect_idle("R5 paused mid-byte", 2);
        set_rdy(1'b1, 1'b1);
        get_bits(5, v, hi);
        check("R5 resumed byte", {23'd0, hi, v}, {23'd0, 1'b0, 8'hB4});
        get_bits(8, v, hi);
        check("R7 following byte", {23'd0, hi, v}, {23'd0, 1'b0, 8'h69});
        set_rdy(1'b1, 1'b0);
        expect_idle("R5 stall at boundary", 2);
        set_rdy(1'b1, 1'b1);
        get_bits(8, v, hi);
        check("R5 byte after boundary stall", {23'd0, hi, v}, {23'd0, 1'b0, 8'hE2});
        expect_idle("R6 idle after stall byte", 1);

        // ignored acknowledge while the holding register is full
        set_rdy(1'b0, 1'b0);
        feed_on = 1'b0;
        @(negedge clk);
        check("R2 req high when empty", {31'd0, buf_req}, 32'd1);
        man_ack  = 1'b1;
        man_data = 8'h3E;
        @(negedge clk);
        man_ack = 1'b0;
        check("R2 req low after capture", {31'd0, buf_req}, 32'd0);
        man_ack  = 1'b1;
        man_data = 8'hC7;
        repeat (2) @(negedge clk);
        man_ack = 1'b0;
        check("R9 req still low", {31'd0, buf_req}, 32'd0);
        set_rdy(1'b1, 1'b1);
        get_bits(8, v, hi);
        check("R9 held byte kept", {23'd0, hi, v}, {23'd0, 1'b0, 8'h3E});
        check("R2 req back after take", {31'd0, buf_req}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule